// File: doc/BRIEF.md
# Transmit Bit-Clock Source Selector with Digital Phase Tracking

This block produces the transmit bit clock of a serial line interface from a fast master clock. A nominal rate of 3.584 MHz divided by 56 gives 64 kbit/s, and divided by 64 gives 56 kbit/s. The clock can come from three places. The first is a divider of the master clock. The second is the recovered receive clock sent back out. The third is the transmit clock of a neighbouring module, which the block follows with a digital phase-tracking divider.

The block watches the neighbour's clock input for activity and moves to it without any configuration. When that clock goes quiet, the block falls back to its own divider. A loopback strap overrides both. The divider that tracks the neighbour is the same counter that runs free when no neighbour is present. Because of this, the phase of the output carries over cleanly between those two sources.

A source change is carried out only while the output is low, and the output is then held low until the new source is also low. The output is itself the clock that a second module would lock to.

Top module: `tx_timing_sel`

## Requirements
- R1: While reset is asserted, `tx_clk` is 0, `tx_src` is 0 (local divider) and `locked` is 0.
- R2: With only the local divider selected, `tx_clk` has a period of 56 master cycles when `rate_56` is 0 and 64 master cycles when `rate_56` is 1.
- R3: When `loop_mode` is 1, `tx_src` becomes 1 and `tx_clk` follows the receive clock with its period, even while the neighbour clock is active. When `loop_mode` returns to 0 with the neighbour clock active, `tx_src` becomes 2.
- R4: Two rising edges on `adj_clk_in` less than 4 bit periods apart make the neighbour clock present, and `tx_src` becomes 2 (neighbour) with no other input changed.
- R5: While the neighbour is selected, each reference edge is compared with the divider count. An edge at count 1 up to half the modulus minus 1 lengthens the current cycle by one master cycle. An edge from half the modulus up to the terminal count shortens the next cycle by one. As a result, a reference whose period is the modulus, or the modulus plus or minus 1, gives a `tx_clk` period equal to the reference period once locked.
- R6: `locked` rises after 8 consecutive reference edges each within one master cycle of count 0, stays 1 while the reference period is within one master cycle of the modulus, and drops when the reference is lost.
- R7: After 4 bit periods with no rising edge on `adj_clk_in`, the neighbour clock counts as lost, `tx_src` returns to 0, and `tx_clk` again runs at the local divider period.
- R8: The receive clock passes through a two-stage synchronizer. In loop mode, a rising edge of `rx_clk_in` appears on `tx_clk` at the third master clock edge after it.
- R9: `tx_src` changes only after a cycle in which `tx_clk` was low. After a change, `tx_clk` stays low until the new source is low, so no high pulse on `tx_clk` is shorter than the shortest high phase among the sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| rate_56 | input | 1 | 0: modulus 56 (64 kbit/s); 1: modulus 64 (56 kbit/s) |
| loop_mode | input | 1 | Strap forcing the receive clock onto the transmit output |
| rx_clk_in | input | 1 | Recovered receive clock, asynchronous |
| adj_clk_in | input | 1 | Neighbour module's transmit clock, asynchronous |
| tx_clk | output | 1 | Transmit bit clock |
| tx_src | output | 2 | Active source: 0 local divider, 1 receive loopback, 2 neighbour |
| locked | output | 1 | Tracking divider is locked to a present neighbour clock |

## Verification
Some properties are checked on every cycle:
- a source change follows a low output cycle;
- the loop strap takes over at the first low output cycle;
- the lock flag clears when tracking is disabled and rises only on a reference edge;
- the activity flag drops once the gap counter reaches its limit.

Other behaviour is shown only by the bench's scenarios:
- the actual periods under each source and rate;
- pull-in to a reference and tracking of one that is one cycle slow or fast;
- the loss timeout and fallback;
- the three-edge latency from the receive input;
- the absence of short high pulses across every switch.

// File: rtl/txsel_pkg.sv
package txsel_pkg;
    typedef enum logic [1:0] {
        SRC_LOCAL = 2'd0,
        SRC_LOOP  = 2'd1,
        SRC_ADJ   = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        CORR_NONE  = 2'd0,
        CORR_LEN   = 2'd1,
        CORR_SHORT = 2'd2
    } corr_e;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            stage_d[i] = (i == 0) ? d_i : stage_q[(i == 0) ? 0 : i - 1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/activity_mon.sv
module activity_mon #(
    parameter int GAP_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic [GAP_W-1:0] limit_i,
    output logic             present_o
);
    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic             present;
    } act_t;

    act_t q, d;

    always_comb begin
        d = q;
        if (edge_i) begin
            if (q.gap < limit_i) d.present = 1'b1;
            d.gap = '0;
        end else if (q.gap >= limit_i) begin
            d.present = 1'b0;
        end else begin
            d.gap = q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.gap     <= '1;
            q.present <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign present_o = q.present;

    // R7: a full quiet window with no edge removes presence
    p_quiet_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.gap >= limit_i && !edge_i) |=> !present_o);
endmodule

// File: rtl/phase_trk.sv
module phase_trk
    import txsel_pkg::*;
#(
    parameter int CNT_W      = 7,
    parameter int LOCK_EDGES = 8,
    parameter int PHASE_TOL  = 1,
    localparam int LOCK_W    = $clog2(LOCK_EDGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] mod_i,
    input  logic             en_i,
    input  logic             edge_i,
    output logic             lvl_o,
    output logic             locked_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        corr_e             corr;
        logic [LOCK_W-1:0] good;
    } trk_t;

    trk_t q, d;

    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] last;
    logic             term, early, late, in_tol;
    corr_e            corr_eff;

    always_comb begin
        half     = mod_i >> 1;
        last     = mod_i - CNT_W'(1);
        term     = (q.cnt >= last);
        early    = edge_i && en_i && (q.cnt != '0) && (q.cnt < half);
        late     = edge_i && en_i && (q.cnt >= half);
        in_tol   = (q.cnt <= CNT_W'(PHASE_TOL)) || (q.cnt >= mod_i - CNT_W'(PHASE_TOL));
        corr_eff = late ? CORR_SHORT : q.corr;

        d = q;
        if (!en_i)      d.corr = CORR_NONE;
        else if (early) d.corr = CORR_LEN;
        else if (late)  d.corr = CORR_SHORT;

        if (term) begin
            d.corr = CORR_NONE;
            case (corr_eff)
                CORR_LEN:   d.cnt = q.cnt;
                CORR_SHORT: d.cnt = CNT_W'(1);
                default:    d.cnt = '0;
            endcase
        end else begin
            d.cnt = q.cnt + 1'b1;
        end

        if (!en_i) begin
            d.good = '0;
        end else if (edge_i) begin
            if (!in_tol)                               d.good = '0;
            else if (q.good != LOCK_W'(LOCK_EDGES))    d.good = q.good + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cnt  <= '0;
            q.corr <= CORR_NONE;
            q.good <= '0;
        end else begin
            q <= d;
        end
    end

    assign lvl_o    = (q.cnt < half);
    assign locked_o = (q.good == LOCK_W'(LOCK_EDGES));

    // R6: tracking disabled means lock is gone next cycle
    p_lock_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !locked_o);
    // R6: lock is only ever gained on a reference edge
    p_lock_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(edge_i));
endmodule

// File: rtl/tx_timing_sel.sv
module tx_timing_sel
    import txsel_pkg::*;
#(
    parameter int MOD_FAST     = 56,
    parameter int MOD_SLOW     = 64,
    parameter int LOSS_PERIODS = 4,
    parameter int LOCK_EDGES   = 8,
    parameter int PHASE_TOL    = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rate_56,
    input  logic       loop_mode,
    input  logic       rx_clk_in,
    input  logic       adj_clk_in,
    output logic       tx_clk,
    output logic [1:0] tx_src,
    output logic       locked
);
    localparam int MOD_MAX = (MOD_SLOW > MOD_FAST) ? MOD_SLOW : MOD_FAST;
    localparam int CNT_W   = $clog2(MOD_MAX + 1);
    localparam int GAP_W   = $clog2(MOD_MAX * LOSS_PERIODS + 1);
    localparam logic [CNT_W-1:0] MODV_FAST = CNT_W'(MOD_FAST);
    localparam logic [CNT_W-1:0] MODV_SLOW = CNT_W'(MOD_SLOW);
    localparam logic [GAP_W-1:0] LIM_FAST  = GAP_W'(MOD_FAST * LOSS_PERIODS);
    localparam logic [GAP_W-1:0] LIM_SLOW  = GAP_W'(MOD_SLOW * LOSS_PERIODS);

    typedef struct packed {
        src_e sel;
        logic mute;
        logic tx;
        logic adj_prev;
    } top_t;

    top_t q, d;

    logic [1:0]       sync_out;
    logic             rx_s, adj_s;
    logic             ref_edge, present;
    logic             trk_lvl, trk_locked;
    logic [CNT_W-1:0] modv;
    logic [GAP_W-1:0] limv;
    src_e             req;

    assign modv = rate_56 ? MODV_SLOW : MODV_FAST;
    assign limv = rate_56 ? LIM_SLOW : LIM_FAST;

    bit_sync #(.W(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({adj_clk_in, rx_clk_in}),
        .q_o   (sync_out)
    );
    assign rx_s  = sync_out[0];
    assign adj_s = sync_out[1];

    assign ref_edge = adj_s && !q.adj_prev;

    activity_mon #(.GAP_W(GAP_W)) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (ref_edge),
        .limit_i   (limv),
        .present_o (present)
    );

    phase_trk #(
        .CNT_W      (CNT_W),
        .LOCK_EDGES (LOCK_EDGES),
        .PHASE_TOL  (PHASE_TOL)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_i    (modv),
        .en_i     (present),
        .edge_i   (ref_edge),
        .lvl_o    (trk_lvl),
        .locked_o (trk_locked)
    );

    function automatic logic src_level(src_e s, logic rx_lvl, logic div_lvl);
        return (s == SRC_LOOP) ? rx_lvl : div_lvl;
    endfunction

    always_comb begin
        if (loop_mode)    req = SRC_LOOP;
        else if (present) req = SRC_ADJ;
        else              req = SRC_LOCAL;

        d = q;
        d.adj_prev = adj_s;
        if (req != q.sel && !q.tx) begin
            d.sel  = req;
            d.mute = 1'b1;
        end
        if (d.mute && !src_level(d.sel, rx_s, trk_lvl)) d.mute = 1'b0;
        d.tx = !d.mute && src_level(d.sel, rx_s, trk_lvl);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sel      <= SRC_LOCAL;
            q.mute     <= 1'b0;
            q.tx       <= 1'b0;
            q.adj_prev <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign tx_clk = q.tx;
    assign tx_src = q.sel;
    assign locked = trk_locked && present;

    // R9: the source only moves after a cycle with the output low
    p_switch_when_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sel != $past(q.sel)) |-> !$past(q.tx));
    // R3: the loop strap takes over at the first low output cycle
    p_loop_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_mode && !q.tx) |=> (tx_src == 2'd1));
endmodule

// File: tb/sim_tx_timing_sel.sv
module sim_tx_timing_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_56 = 1'b0;
    logic       loop_mode = 1'b0;
    logic       rx_clk_in = 1'b0;
    logic       adj_clk_in = 1'b0;
    logic       tx_clk;
    logic [1:0] tx_src;
    logic       locked;

    int total = 0;
    int fails = 0;
    bit done = 0;

    bit adj_on = 0;
    int adj_per = 56;
    bit rx_on = 0;
    int rx_per = 50;

    bit mon_en = 0;
    int hi_run = 0;
    int min_hi = 100000;

    always #5 clk = ~clk;

    tx_timing_sel u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_56    (rate_56),
        .loop_mode  (loop_mode),
        .rx_clk_in  (rx_clk_in),
        .adj_clk_in (adj_clk_in),
        .tx_clk     (tx_clk),
        .tx_src     (tx_src),
        .locked     (locked)
    );

    initial begin
        forever begin
            if (adj_on) begin
                int p;
                p = adj_per;
                adj_clk_in = 1'b1;
                repeat (28) @(negedge clk);
                adj_clk_in = 1'b0;
                repeat (p - 28) @(negedge clk);
            end else begin
                adj_clk_in = 1'b0;
                @(negedge clk);
            end
        end
    end

    initial begin
        forever begin
            if (rx_on) begin
                rx_clk_in = 1'b1;
                repeat (rx_per / 2) @(negedge clk);
                rx_clk_in = 1'b0;
                repeat (rx_per - rx_per / 2) @(negedge clk);
            end else begin
                rx_clk_in = 1'b0;
                @(negedge clk);
            end
        end
    end

    always @(negedge clk) begin
        if (mon_en) begin
            if (tx_clk) hi_run++;
            else begin
                if (hi_run > 0 && hi_run < min_hi) min_hi = hi_run;
                hi_run = 0;
            end
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_rise(output int n);
        logic prev;
        n = 0;
        prev = tx_clk;
        while (n < 2000) begin
            @(negedge clk);
            n++;
            if (!prev && tx_clk) break;
            prev = tx_clk;
        end
    endtask

    task automatic measure(output int p);
        int dummy;
        wait_rise(dummy);
        wait_rise(p);
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        chk("R1", "tx_clk in reset", int'(tx_clk), 0);
        chk("R1", "tx_src in reset", int'(tx_src), 0);
        chk("R1", "locked in reset", int'(locked), 0);
        rst_n = 1'b1;
        mon_en = 1;
    endtask

    task automatic t_local();
        int p;
        measure(p);
        chk("R2", "local period rate 64k", p, 56);
        chk("R2", "source local", int'(tx_src), 0);
        rate_56 = 1'b1;
        repeat (200) @(negedge clk);
        measure(p);
        chk("R2", "local period rate 56k", p, 64);
        rate_56 = 1'b0;
        repeat (200) @(negedge clk);
    endtask

    task automatic t_adj_lock();
        int p;
        int n;
        adj_per = 56;
        adj_on = 1;
        repeat (300) @(negedge clk);
        chk("R4", "auto switch to neighbour", int'(tx_src), 2);
        n = 0;
        while (!locked && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk("R6", "lock gained", int'(locked), 1);
        measure(p);
        chk("R5", "locked period at 56", p, 56);
    endtask

    task automatic t_adj_track();
        int p;
        adj_per = 57;
        repeat (6 * 57) @(negedge clk);
        measure(p);
        chk("R5", "tracks slow reference", p, 57);
        chk("R6", "lock kept at +1", int'(locked), 1);
        adj_per = 55;
        repeat (6 * 57) @(negedge clk);
        measure(p);
        chk("R5", "tracks fast reference", p, 55);
        chk("R6", "lock kept at -1", int'(locked), 1);
        adj_per = 56;
        repeat (6 * 56) @(negedge clk);
    endtask

    task automatic t_loop();
        int p;
        rx_per = 50;
        rx_on = 1;
        loop_mode = 1'b1;
        repeat (300) @(negedge clk);
        chk("R3", "loop source with neighbour active", int'(tx_src), 1);
        measure(p);
        chk("R3", "loop period follows rx", p, 50);
    endtask

    task automatic t_sync();
        @(posedge rx_clk_in);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R8", "tx_clk after two edges", int'(tx_clk), 0);
        @(negedge clk);
        chk("R8", "tx_clk after third edge", int'(tx_clk), 1);
    endtask

    task automatic t_priority();
        loop_mode = 1'b0;
        repeat (300) @(negedge clk);
        chk("R3", "neighbour after loop released", int'(tx_src), 2);
        rx_on = 0;
    endtask

    task automatic t_loss();
        int p;
        adj_on = 0;
        repeat (4 * 56 + 150) @(negedge clk);
        chk("R7", "fallback to local", int'(tx_src), 0);
        chk("R6", "lock dropped on loss", int'(locked), 0);
        measure(p);
        chk("R7", "local period after loss", p, 56);
    endtask

    task automatic t_runt();
        chk("R9", "no short high pulse", (min_hi >= 25) ? 1 : 0, 1);
    endtask

    initial begin
        t_reset();
        t_local();
        t_adj_lock();
        t_adj_track();
        t_loop();
        t_sync();
        t_priority();
        t_loss();
        t_runt();
        done = 1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            report();
        end
    end
endmodule